// File: doc/BRIEF.md
# Single-Edge PWM Match Timer

This block is an up-counter with a small set of match channels. Each channel either produces a single-edge PWM waveform or drives a fixed level. A channel marked as a cycle channel makes the counter restart at zero on the tick after the count equals its match value, and that sets the PWM period. Each PWM channel is low at the start of a period and goes high once the counter reaches its match value. Match values of zero, equal to the period end, or beyond it give defined waveforms: always high, a one-tick pulse, or always low.

Software-style configuration goes through a single-cycle write port. Addresses `0` to `NCH-1` load the match value of the channel with that index. Address `NCH` loads the control word. Match values have no shadow copy, so a new value takes effect from the very next counter comparison. That includes a rewrite in the middle of a period. Outputs are registered, so every pin change appears one clock after the count that causes it.

Top module: `pwm_match_timer`

## Requirements
- R1: While `rst` is high, at the next clock edge `cnt_o` becomes 0, every `pwm_o` bit becomes 0, and all match values and control fields are cleared.
- R2: When `cnt_o` equals the match value of any channel whose restart-select bit is set, the next value of `cnt_o` is 0. Any channel can act as the cycle channel.
- R3: For a PWM-enabled channel with match value M, 0 < M < C, where C is the cycle match value: the pin is high from the clock after count M until the clock after count 0. Each period of C+1 clocks it is high for exactly C-M+1 clocks (M=41, C=100 gives 60; M=65 gives 36).
- R4: A PWM channel whose match value equals C gives a pulse exactly one clock wide in every period.
- R5: A PWM channel with match value 0 is high after the first clock at count 0 and then stays high continuously.
- R6: A PWM channel with match value above C stays low. If its pin is high when such a value is written, the pin clears on the clock after the next count 0.
- R7: When a channel's PWM-enable bit is clear, its pin equals that channel's external level bit, one clock after that bit is written.
- R8: A match write takes effect at once. The compare on the clock after the write uses the new value, and there is no wait for the next period.
- R9: Control word layout: bits [NCH-1:0] are the PWM enables, bits [2*NCH-1:NCH] are the restart selects, and bits [3*NCH-1:2*NCH] are the external levels, with channel k at the lowest position plus k. Writes to addresses above NCH change nothing.
- R10: When no restart match occurs, `cnt_o` increments by one each clock and wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NCH+1) | Register address: match k at k, control at NCH |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current counter value |
| pwm_o | output | NCH | Channel pins |

## Verification
The bench builds the block with a 16-bit counter and four channels. With that width the free-running wrap from all ones to zero happens after 65,536 clocks, so the test reaches it in a short run. Four channels cover periods set by channel 3 and also by channel 0. They also cover a cycle channel that is itself PWM-enabled, so it gives the one-tick pulse, and a mix of enabled and fixed-level pins. Every clock is compared against a cycle-accurate model kept in the bench. Separate per-period high-time counts check the zero, equal and beyond-period corner cases, and a mid-period rewrite is checked on its own.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic [1:0] {
        RS_NONE  = 2'd0,
        RS_MATCH = 2'd1,
        RS_CTRL  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic at_match;
        logic at_start;
    } chan_evt_t;

    function automatic reg_sel_e decode_addr(int unsigned addr, int unsigned nch);
        if (addr < nch)       return RS_MATCH;
        else if (addr == nch) return RS_CTRL;
        else                  return RS_NONE;
    endfunction

    // a reached match wins over the period-start clear
    function automatic logic level_next(chan_evt_t ev, logic cur);
        if (ev.at_match)      return 1'b1;
        else if (ev.at_start) return 1'b0;
        else                  return cur;
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs #(
    parameter int CNT_W = 32,
    parameter int NCH   = 4,
    localparam int AW   = $clog2(NCH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [CNT_W-1:0]           wr_data,
    output logic [NCH-1:0][CNT_W-1:0]  mval,
    output logic [NCH-1:0]             en,
    output logic [NCH-1:0]             rsel,
    output logic [NCH-1:0]             ext
);
    import pwmt_pkg::*;

    reg_sel_e sel;
    assign sel = decode_addr(int'(wr_addr), NCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            mval <= '0;
            en   <= '0;
            rsel <= '0;
            ext  <= '0;
        end else if (wr_en) begin
            if (sel == RS_CTRL) begin
                en   <= wr_data[NCH-1:0];
                rsel <= wr_data[2*NCH-1:NCH];
                ext  <= wr_data[3*NCH-1:2*NCH];
            end
            for (int k = 0; k < NCH; k++) begin
                if (sel == RS_MATCH && wr_addr == AW'(k))
                    mval[k] <= wr_data;
            end
        end
    end

    generate
        if (CNT_W > 3 * NCH) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^wr_data[CNT_W-1:3*NCH];
        end
    endgenerate

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int CNT_W = 32,
    parameter int NCH   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0][CNT_W-1:0]  mval,
    input  logic [NCH-1:0]             rsel,
    output logic [CNT_W-1:0]           cnt
);
    logic [NCH-1:0] eq;
    logic           restart;

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_eq
            assign eq[k] = rsel[k] && (cnt == mval[k]);
        end
    endgenerate

    assign restart = |eq;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (restart) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] mval,
    input  logic             en,
    input  logic             ext,
    output logic             pin
);
    import pwmt_pkg::*;

    chan_evt_t ev;
    logic      lvl_q;
    logic      lvl_d;

    assign ev.at_match = (cnt == mval);
    assign ev.at_start = (cnt == '0);
    assign lvl_d       = level_next(ev, lvl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            pin   <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
            pin   <= en ? lvl_d : ext;
        end
    end

endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
    parameter int CNT_W = 32,
    parameter int NCH   = 4,
    localparam int AW   = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic [NCH-1:0]   pwm_o
);
    logic [NCH-1:0][CNT_W-1:0] match_r;
    logic [NCH-1:0]            en_r;
    logic [NCH-1:0]            rsel_r;
    logic [NCH-1:0]            ext_r;

    pwmt_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mval(match_r), .en(en_r), .rsel(rsel_r), .ext(ext_r)
    );

    pwmt_counter #(.CNT_W(CNT_W), .NCH(NCH)) u_cnt (
        .clk(clk), .rst(rst), .mval(match_r), .rsel(rsel_r), .cnt(cnt_o)
    );

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            pwmt_channel #(.CNT_W(CNT_W)) u_ch (
                .clk(clk), .rst(rst), .cnt(cnt_o), .mval(match_r[k]),
                .en(en_r[k]), .ext(ext_r[k]), .pin(pwm_o[k])
            );
        end
    endgenerate

endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk #(
    parameter int CNT_W = 32,
    parameter int NCH   = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [CNT_W-1:0]          cnt,
    input logic [NCH-1:0]            pin,
    input logic [NCH-1:0][CNT_W-1:0] mval,
    input logic [NCH-1:0]            en,
    input logic [NCH-1:0]            rsel,
    input logic [NCH-1:0]            ext
);
    logic [NCH-1:0] rhit;

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_a
            assign rhit[k] = rsel[k] && (cnt == mval[k]);

            // R2
            restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
                (rsel[k] && cnt == mval[k]) |=> (cnt == '0));

            // R7
            ext_level_chk: assert property (@(posedge clk) disable iff (rst)
                !en[k] |=> (pin[k] == $past(ext[k])));

            // R3
            rise_on_match_chk: assert property (@(posedge clk) disable iff (rst)
                (en[k] && cnt == mval[k]) |=> pin[k]);

            // R3
            low_at_start_chk: assert property (@(posedge clk) disable iff (rst)
                (en[k] && cnt == '0 && mval[k] != '0) |=> !pin[k]);
        end
    endgenerate

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rhit == '0) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && pin == '0));

endmodule

bind pwm_match_timer pwmt_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .cnt(cnt_o), .pin(pwm_o),
    .mval(match_r), .en(en_r), .rsel(rsel_r), .ext(ext_r)
);

// File: tb/pwm_match_timer_test.sv
`timescale 1ns/1ps
module pwm_match_timer_test;
    localparam int CW  = 16;
    localparam int NC  = 4;
    localparam int AW  = $clog2(NC + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] cnt_o;
    logic [NC-1:0] pwm_o;

    pwm_match_timer #(.CNT_W(CW), .NCH(NC)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_o(cnt_o), .pwm_o(pwm_o)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    string tag = "R1";

    // model state
    logic [CW-1:0] m_cnt = '0;
    logic [CW-1:0] m_val [NC];
    logic [NC-1:0] m_en = '0, m_rsel = '0, m_ext = '0, m_lvl = '0, m_pin = '0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: model advance, then compare after the edge
    task automatic tick();
        logic          hit;
        logic [CW-1:0] n_cnt;
        logic [NC-1:0] n_lvl, n_pin;
        hit = 1'b0;
        for (int k = 0; k < NC; k++)
            if (m_rsel[k] && m_cnt == m_val[k]) hit = 1'b1;
        n_cnt = hit ? '0 : m_cnt + 1'b1;
        for (int k = 0; k < NC; k++) begin
            n_lvl[k] = (m_cnt == m_val[k]) ? 1'b1 : ((m_cnt == '0) ? 1'b0 : m_lvl[k]);
            n_pin[k] = m_en[k] ? n_lvl[k] : m_ext[k];
        end
        if (rst) begin
            n_cnt = '0; n_lvl = '0; n_pin = '0;
            m_en = '0; m_rsel = '0; m_ext = '0;
            for (int k = 0; k < NC; k++) m_val[k] = '0;
        end else if (wr_en) begin
            if (int'(wr_addr) < NC) m_val[wr_addr] = wr_data;
            else if (int'(wr_addr) == NC) begin
                m_en   = wr_data[NC-1:0];
                m_rsel = wr_data[2*NC-1:NC];
                m_ext  = wr_data[3*NC-1:2*NC];
            end
        end
        m_cnt = n_cnt; m_lvl = n_lvl; m_pin = n_pin;
        @(posedge clk);
        #1;
        check({tag, " count"}, 32'(cnt_o), 32'(m_cnt));
        check({tag, " pins"}, 32'(pwm_o), 32'(m_pin));
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_cnt(int v);
        for (int i = 0; i < 70000 && int'(cnt_o) != v; i++) tick();
    endtask

    // high clocks of channel ch over one period of p clocks
    task automatic high_count(int ch, int p, string req, int exp);
        int h;
        h = 0;
        for (int i = 0; i < p; i++) begin
            tick();
            if (pwm_o[ch]) h++;
        end
        check(req, 32'(h), 32'(exp));
    endtask

    // {m0, m1, m2, m3, control, clocks}; control: en[3:0] rsel[7:4] ext[11:8]
    localparam logic [15:0] ROWS [5][6] = '{
        '{16'd41, 16'd65,  16'd100, 16'd100, 16'h087, 16'd320},
        '{16'd0,  16'd150, 16'd10,  16'd20,  16'h087, 16'd100},
        '{16'd5,  16'd5,   16'd5,   16'd8,   16'h483, 16'd60},
        '{16'd3,  16'd7,   16'd12,  16'd12,  16'h08F, 16'd50},
        '{16'd9,  16'd4,   16'd2,   16'd30,  16'h01E, 16'd90}
    };
    localparam string RTAG [5] = '{"R3", "R6", "R7", "R4", "R2"};

    initial begin
        for (int k = 0; k < NC; k++) m_val[k] = '0;
        // R1 reset state
        tag = "R1";
        run(3);
        check("R1 reset count", 32'(cnt_o), 32'd0);
        check("R1 reset pins", 32'(pwm_o), 32'd0);
        rst = 1'b0;
        run(5);

        // table walk, model compared every clock
        for (int r = 0; r < 5; r++) begin
            tag = "R9";
            for (int k = 0; k < NC; k++) wr(k, int'(ROWS[r][k]));
            wr(NC, int'(ROWS[r][4]));
            tag = RTAG[r];
            run(int'(ROWS[r][5]));
        end

        // R9 write above control address is ignored
        tag = "R9";
        wr(NC + 1, 16'hFFFF);
        run(40);

        // R3 / R4 high time per period, C=100
        tag = "R3";
        wr(0, 41); wr(1, 65); wr(2, 100); wr(3, 100); wr(NC, 16'h087);
        wait_cnt(0);
        high_count(0, 101, "R3 match 41 high clocks", 60);
        wait_cnt(0);
        high_count(1, 101, "R3 match 65 high clocks", 36);
        wait_cnt(0);
        tag = "R4";
        high_count(2, 101, "R4 match equal period high clocks", 1);

        // R5 zero match and R6 beyond period
        tag = "R5";
        wr(0, 0); wr(1, 300);
        wait_cnt(1);
        high_count(0, 101, "R5 zero match high clocks", 101);
        tag = "R6";
        high_count(1, 101, "R6 above period high clocks", 0);

        // R8 mid-period rewrite: raise to beyond period while high
        tag = "R8";
        wr(0, 41);
        wait_cnt(50);
        check("R8 pin high before rewrite", 32'(pwm_o[0]), 32'd1);
        wr(0, 200);
        wait_cnt(1);
        check("R6 cleared at next start", 32'(pwm_o[0]), 32'd0);
        // lower match below current count: no rise this period
        wait_cnt(30);
        wr(0, 20);
        run(10);
        check("R8 no rise after passed match", 32'(pwm_o[0]), 32'd0);
        wait_cnt(21);
        check("R8 new match used next period", 32'(pwm_o[0]), 32'd1);

        // R7 fixed levels after disable
        tag = "R7";
        wr(NC, 16'hA80);
        run(2);
        check("R7 external levels", 32'(pwm_o), 32'hA);

        // R10 free-running wrap
        tag = "R10";
        wr(NC, 16'h000);
        wait_cnt(65535);
        tick();
        check("R10 wrap to zero", 32'(cnt_o), 32'd0);

        // R1 reset mid-run
        tag = "R1";
        wr(3, 12); wr(0, 0); wr(NC, 16'h08F);
        run(20);
        rst = 1'b1;
        tick();
        check("R1 reset mid-run count", 32'(cnt_o), 32'd0);
        check("R1 reset mid-run pins", 32'(pwm_o), 32'd0);
        rst = 1'b0;
        run(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule